// File: doc/BRIEF.md
# Segmented Trigger Capture Analyzer

This block is an on-chip logic analyzer core. A bus of probe signals is registered on every rising edge of the system clock, and each bit is compared against its own trigger condition: level high, level low, rising edge, falling edge or don't care. The overall trigger is the AND of every bit's result, so a bit set to don't care never blocks it.

The capture memory is split into equal segments. After an arm command the analyzer waits for the trigger. When the trigger is seen, it writes that sample and the samples that follow into the current segment. It then moves on to the next segment and waits for another trigger. When the last segment is full, capture stops and a done flag stays high. Stored samples are read back through a registered port that takes a segment index and an offset within the segment.

Top module: `seg_trigger_analyzer`

## Requirements
- R1: Each probe bit i takes a 3-bit condition code at `cond_i[3i+2:3i]`: 0 = don't care, 1 = high, 2 = low, 3 = rising, 4 = falling; codes 5 to 7 act as don't care. High and low test only the current registered sample.
- R2: Rising means the current sample is 1 and the previous one was 0. Falling means the current sample is 0 and the previous one was 1. The previous sample is the probe registered one clock earlier.
- R3: The trigger fires only when every bit's condition holds at once. With all bits set to don't care, it fires on the first evaluated sample.
- R4: After reset, and in the idle state, nothing is written, `seg_full_o` is all zero and `done_o` is 0, whatever the probe does.
- R5: The sample that fires the trigger is stored at offset 0 of the current segment. The next SEG_LEN-1 consecutive samples (31 by default) follow it at offsets 1 upward.
- R6: Successive triggers fill segments 0, 1, 2 and so on in order. Bit k of `seg_full_o` rises in the clock that stores the last sample of segment k and stays set. The set bits always form a run starting at bit 0, and at most one new bit appears per clock.
- R7: A trigger that arrives while a segment is filling is ignored. Trigger evaluation resumes on the sample that follows the segment's last sample.
- R8: Once the last segment (segment 7 by default) is full, `done_o` is 1 with every `seg_full_o` bit set. Nothing more is written, and both flags and memory hold until clear or arm.
- R9: `clear_i` returns the block to idle and clears all flags. `arm_i` clears all flags and starts waiting for a trigger into segment 0; it works from any state, including done. If both are high, clear wins.
- R10: `rd_data_o` shows the sample at (`rd_seg_i`, `rd_off_i`) one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and system clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_i | input | PROBE_W | Monitored signals |
| cond_i | input | 3*PROBE_W | Per-bit trigger condition codes |
| arm_i | input | 1 | Start a new capture run from segment 0 |
| clear_i | input | 1 | Return to idle and clear flags |
| rd_seg_i | input | log2(SEG_NUM) | Segment index to read |
| rd_off_i | input | log2(SEG_LEN) | Sample offset inside the segment |
| rd_data_o | output | PROBE_W | Stored sample, one clock after the address |
| seg_full_o | output | SEG_NUM | One flag per completed segment |
| done_o | output | 1 | All segments captured |

## Verification
A probe value driven before clock edge k is registered at k. It is judged against the trigger during the following cycle and lands in memory at edge k+1. The bench therefore pairs each driven value with the trigger decision of its own step, and its reference model uses that same one-step alignment.

The `seg_full_o` and `done_o` flags rise at the edge that writes a segment's last sample. A clear or arm takes effect at the very next edge. Read data appears one edge after the address. All outputs are sampled at the falling edge, after the relevant rising edge has passed, and the condition-table rows wait a full segment length plus margin before checking the flag.

// File: rtl/sca_pkg.sv
package sca_pkg;

    localparam int COND_W = 3;

    typedef enum logic [COND_W-1:0] {
        COND_ANY  = 3'd0,
        COND_HIGH = 3'd1,
        COND_LOW  = 3'd2,
        COND_RISE = 3'd3,
        COND_FALL = 3'd4
    } cond_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_FILL,
        ST_DONE
    } cap_state_e;

    // Result of one bit's condition given its present and previous sample.
    function automatic logic bit_cond_ok(logic [COND_W-1:0] code, logic now_v, logic was_v);
        logic ok;
        case (code)
            COND_HIGH: ok = now_v;
            COND_LOW:  ok = ~now_v;
            COND_RISE: ok = now_v & ~was_v;
            COND_FALL: ok = ~now_v & was_v;
            default:   ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/sca_trig_match.sv
module sca_trig_match
    import sca_pkg::*;
#(
    parameter int PROBE_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [PROBE_W-1:0]          probe_i,
    input  logic [COND_W*PROBE_W-1:0]   cond_i,
    output logic [PROBE_W-1:0]          sample_o,
    output logic                        match_o
);

    logic [PROBE_W-1:0] cur_q;
    logic [PROBE_W-1:0] prev_q;
    logic [PROBE_W-1:0] bit_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            cur_q  <= probe_i;
            prev_q <= cur_q;
        end
    end

    for (genvar gi = 0; gi < PROBE_W; gi++) begin : g_bit
        always_comb begin
            bit_hit[gi] = bit_cond_ok(cond_i[gi*COND_W +: COND_W], cur_q[gi], prev_q[gi]);
        end
    end

    assign match_o  = &bit_hit;
    assign sample_o = cur_q;

endmodule

// File: rtl/sca_capture_ctrl.sv
module sca_capture_ctrl
    import sca_pkg::*;
#(
    parameter int SEG_NUM = 8,
    parameter int SEG_LEN = 32,
    localparam int SEG_W  = $clog2(SEG_NUM),
    localparam int OFF_W  = $clog2(SEG_LEN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 arm_i,
    input  logic                 clear_i,
    input  logic                 match_i,
    output logic                 wr_en_o,
    output logic [SEG_W-1:0]     wr_seg_o,
    output logic [OFF_W-1:0]     wr_off_o,
    output logic [SEG_NUM-1:0]   seg_full_o,
    output logic                 done_o
);

    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(SEG_LEN - 1);
    localparam logic [SEG_W-1:0] LAST_SEG = SEG_W'(SEG_NUM - 1);

    cap_state_e         state_q;
    logic [SEG_W-1:0]   seg_q;
    logic [OFF_W-1:0]   cnt_q;
    logic [SEG_NUM-1:0] full_q;

    always_comb begin
        wr_en_o  = (state_q == ST_FILL) || ((state_q == ST_WAIT) && match_i);
        wr_seg_o = seg_q;
        wr_off_o = (state_q == ST_FILL) ? cnt_q : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            state_q <= ST_IDLE;
            seg_q   <= '0;
            cnt_q   <= '0;
            full_q  <= '0;
        end else if (arm_i) begin
            state_q <= ST_WAIT;
            seg_q   <= '0;
            cnt_q   <= '0;
            full_q  <= '0;
        end else begin
            case (state_q)
                ST_WAIT: begin
                    if (match_i) begin
                        cnt_q   <= OFF_W'(1);
                        state_q <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (cnt_q == LAST_OFF) begin
                        cnt_q         <= '0;
                        full_q[seg_q] <= 1'b1;
                        if (seg_q == LAST_SEG) begin
                            state_q <= ST_DONE;
                        end else begin
                            seg_q   <= seg_q + SEG_W'(1);
                            state_q <= ST_WAIT;
                        end
                    end else begin
                        cnt_q <= cnt_q + OFF_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign seg_full_o = full_q;
    assign done_o     = (state_q == ST_DONE);

endmodule

// File: rtl/sca_sample_ram.sv
module sca_sample_ram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        rdata_o <= mem_q[raddr_i];
    end

endmodule

// File: rtl/seg_trigger_analyzer.sv
module seg_trigger_analyzer
    import sca_pkg::*;
#(
    parameter int PROBE_W = 8,
    parameter int SEG_NUM = 8,
    parameter int SEG_LEN = 32,
    localparam int SEG_W  = $clog2(SEG_NUM),
    localparam int OFF_W  = $clog2(SEG_LEN)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [PROBE_W-1:0]         probe_i,
    input  logic [COND_W*PROBE_W-1:0]  cond_i,
    input  logic                       arm_i,
    input  logic                       clear_i,
    input  logic [SEG_W-1:0]           rd_seg_i,
    input  logic [OFF_W-1:0]           rd_off_i,
    output logic [PROBE_W-1:0]         rd_data_o,
    output logic [SEG_NUM-1:0]         seg_full_o,
    output logic                       done_o
);

    localparam int DEPTH = SEG_NUM * SEG_LEN;

    logic [PROBE_W-1:0] sample;
    logic               match;
    logic               wr_en;
    logic [SEG_W-1:0]   wr_seg;
    logic [OFF_W-1:0]   wr_off;

    sca_trig_match #(.PROBE_W(PROBE_W)) u_match (
        .clk      (clk),
        .rst      (rst),
        .probe_i  (probe_i),
        .cond_i   (cond_i),
        .sample_o (sample),
        .match_o  (match)
    );

    sca_capture_ctrl #(.SEG_NUM(SEG_NUM), .SEG_LEN(SEG_LEN)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .arm_i      (arm_i),
        .clear_i    (clear_i),
        .match_i    (match),
        .wr_en_o    (wr_en),
        .wr_seg_o   (wr_seg),
        .wr_off_o   (wr_off),
        .seg_full_o (seg_full_o),
        .done_o     (done_o)
    );

    sca_sample_ram #(.DATA_W(PROBE_W), .DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .we_i    (wr_en),
        .waddr_i ({wr_seg, wr_off}),
        .wdata_i (sample),
        .raddr_i ({rd_seg_i, rd_off_i}),
        .rdata_o (rd_data_o)
    );

endmodule

// File: rtl/sca_analyzer_chk.sv
module sca_analyzer_chk #(
    parameter int SEG_NUM = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               arm_i,
    input logic               clear_i,
    input logic [SEG_NUM-1:0] seg_full_o,
    input logic               done_o
);

    AST_DONE_ALL_FULL: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (&seg_full_o)); // R8

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done_o && !clear_i && !arm_i) |=> done_o); // R8

    AST_FULL_PREFIX: assert property (@(posedge clk) disable iff (rst)
        ((seg_full_o + SEG_NUM'(1)) & seg_full_o) == '0); // R6

    AST_ONE_NEW_FULL: assert property (@(posedge clk) disable iff (rst)
        $countones(seg_full_o & ~$past(seg_full_o)) <= 1); // R6

    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!clear_i && !arm_i) |=> ((seg_full_o & $past(seg_full_o)) == $past(seg_full_o))); // R6

    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (seg_full_o == '0 && !done_o)); // R9

    AST_ARM_RESTART: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> (seg_full_o == '0 && !done_o)); // R9

endmodule

bind seg_trigger_analyzer sca_analyzer_chk #(.SEG_NUM(SEG_NUM)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .arm_i      (arm_i),
    .clear_i    (clear_i),
    .seg_full_o (seg_full_o),
    .done_o     (done_o)
);

// File: tb/seg_trigger_analyzer_tb_top.sv
module seg_trigger_analyzer_tb_top;

    localparam int PW = 8;
    localparam int SN = 8;
    localparam int SL = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] probe_i = '0;
    logic [3*PW-1:0] cond_i = '0;
    logic          arm_i = 1'b0;
    logic          clear_i = 1'b0;
    logic [2:0]    rd_seg_i = '0;
    logic [4:0]    rd_off_i = '0;
    logic [PW-1:0] rd_data_o;
    logic [SN-1:0] seg_full_o;
    logic          done_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    seg_trigger_analyzer dut_i (
        .clk(clk), .rst(rst), .probe_i(probe_i), .cond_i(cond_i),
        .arm_i(arm_i), .clear_i(clear_i), .rd_seg_i(rd_seg_i), .rd_off_i(rd_off_i),
        .rd_data_o(rd_data_o), .seg_full_o(seg_full_o), .done_o(done_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic read_at(input int s, input int o, output logic [PW-1:0] d);
        rd_seg_i = 3'(s);
        rd_off_i = 5'(o);
        @(negedge clk);
        d = rd_data_o;
    endtask

    // {cond bit1, cond bit0, previous probe, current probe, trigger expected}
    localparam int NV = 12;
    localparam logic [22:0] VEC [NV] = '{
        {3'd0, 3'd1, 8'h00, 8'h01, 1'b1},  // R1 high hit
        {3'd0, 3'd1, 8'h00, 8'h00, 1'b0},  // R1 high miss
        {3'd0, 3'd2, 8'h01, 8'hA0, 1'b1},  // R1 low hit
        {3'd0, 3'd2, 8'h00, 8'h51, 1'b0},  // R1 low miss
        {3'd0, 3'd3, 8'h00, 8'h01, 1'b1},  // R2 rise hit
        {3'd0, 3'd3, 8'h01, 8'h01, 1'b0},  // R2 rise miss
        {3'd0, 3'd4, 8'h01, 8'h00, 1'b1},  // R2 fall hit
        {3'd0, 3'd4, 8'h00, 8'h00, 1'b0},  // R2 fall miss
        {3'd0, 3'd0, 8'h33, 8'hC4, 1'b1},  // R3 all don't care
        {3'd4, 3'd1, 8'h02, 8'h01, 1'b1},  // R3 high AND fall
        {3'd4, 3'd1, 8'h03, 8'h03, 1'b0},  // R3 fall missing
        {3'd3, 3'd1, 8'h00, 8'h02, 1'b0}   // R3 high missing
    };

    logic [PW-1:0] exp_mem [SN*SL];

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [PW-1:0] d;
        logic [PW-1:0] d2;
        logic [PW-1:0] v;
        logic [PW-1:0] pv;
        int mst;
        int mseg;
        int mcnt;

        // Reset state and idle behaviour
        wait_cyc(3);
        rst = 1'b0;
        @(negedge clk);
        chk("R4 seg_full after reset", 32'(seg_full_o), 0);
        chk("R4 done after reset", 32'(done_o), 0);
        probe_i = 8'hFF;
        cond_i = '0;
        wait_cyc(40);
        chk("R4 idle ignores probe", 32'(seg_full_o), 0);

        // Condition table
        for (int k = 0; k < NV; k++) begin
            clear_i = 1'b1;
            probe_i = VEC[k][16:9];
            @(negedge clk);
            clear_i = 1'b0;
            arm_i   = 1'b1;
            cond_i  = {18'd0, VEC[k][22:20], VEC[k][19:17]};
            probe_i = VEC[k][8:1];
            @(negedge clk);
            arm_i = 1'b0;
            wait_cyc(SL + 3);
            chk($sformatf("R1/R2/R3 row %0d trigger", k), 32'(seg_full_o[0]), 32'(VEC[k][0]));
            if (VEC[k][0]) begin
                read_at(0, 0, d);
                chk($sformatf("R5 row %0d offset 0", k), 32'(d), 32'(VEC[k][8:1]));
            end
        end

        // Segmented capture against a reference model (bit0 rising)
        clear_i = 1'b1;
        probe_i = '0;
        @(negedge clk);
        clear_i = 1'b0;
        cond_i = {21'd0, 3'd3};
        for (int i = 0; i < SN*SL; i++) exp_mem[i] = '0;
        mst = 0; mseg = 0; mcnt = 0; pv = '0;
        for (int t = 0; t < 400; t++) begin
            if (t == 60) chk("R6 only segment 0 full at step 60", 32'(seg_full_o), 1);
            v = {7'(t), ((t % 20) >= 10) ? 1'b1 : 1'b0};
            probe_i = v;
            arm_i = (t == 0);
            if (t == 0) mst = 1;
            if (mst == 1 && v[0] && !pv[0]) begin
                exp_mem[mseg*SL] = v;
                mcnt = 1;
                mst = 2;
            end else if (mst == 2) begin
                exp_mem[mseg*SL + mcnt] = v;
                if (mcnt == SL - 1) begin
                    mcnt = 0;
                    if (mseg == SN - 1) mst = 3;
                    else begin mseg++; mst = 1; end
                end else mcnt++;
            end
            pv = v;
            @(negedge clk);
        end
        arm_i = 1'b0;
        wait_cyc(2);
        chk("R8 done after last segment", 32'(done_o), 1);
        chk("R6 all segment flags", 32'(seg_full_o), 32'hFF);
        for (int s = 0; s < SN; s++) begin
            for (int o = 0; o < SL; o++) begin
                read_at(s, o, d);
                chk($sformatf("R5/R6/R8 seg %0d off %0d", s, o), 32'(d), 32'(exp_mem[s*SL + o]));
            end
        end
        read_at(1, 0, d);
        chk("R7 seg1 starts at rise 50 not 30", 32'(d), 32'({7'd50, 1'b1}));

        // Read latency
        read_at(0, 0, d);
        rd_seg_i = 3'd1;
        rd_off_i = 5'd0;
        #1;
        chk("R10 data unchanged before edge", 32'(rd_data_o), 32'(d));
        @(negedge clk);
        d2 = rd_data_o;
        chk("R10 data after one edge", 32'(d2), 32'(exp_mem[SL]));

        // Clear, clear-over-arm, all-don't-care run, arm from done
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        chk("R9 clear flags", 32'(seg_full_o), 0);
        chk("R9 clear done", 32'(done_o), 0);
        cond_i = '0;
        clear_i = 1'b1;
        arm_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        arm_i = 1'b0;
        wait_cyc(SL + 5);
        chk("R9 clear beats arm", 32'(seg_full_o), 0);
        arm_i = 1'b1;
        @(negedge clk);
        arm_i = 1'b0;
        wait_cyc(SN*SL + 20);
        chk("R3 free-running done", 32'(done_o), 1);
        chk("R8 flags held", 32'(seg_full_o), 32'hFF);
        arm_i = 1'b1;
        @(negedge clk);
        arm_i = 1'b0;
        chk("R9 arm from done clears flags", 32'(seg_full_o), 0);
        chk("R9 arm from done clears done", 32'(done_o), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule